// File: doc/BRIEF.md
# DDR Read Strobe Gate Controller

This block tells a DDR memory controller when the incoming data strobe can be trusted. When the bus is idle the strobe floats at the termination midpoint, and its level there means nothing. The block therefore does not treat the strobe as a clock. It builds a gate window from the read command and a cycle count. For each strobe lane it opens the gate during the low preamble, keeps it open for the burst, and closes it again. Inside the gate it reports the gated strobe level and the rising and falling strobe edges. It also flags a preamble that is not low, or a first rising edge that is missing. Finally it drives the direction control of the strobe pad.

`clk` runs at twice the memory clock, so one `clk` cycle is one half memory cycle. The timing works out in `clk` cycles as follows:
- A programmed read latency of L memory cycles is 2·L cycles.
- The preamble lasts two cycles.
- A burst of B beats lasts B cycles, which is B/2 memory cycles.

Every lane has a 2-bit start offset that moves its gate later by 0 to 3 half cycles, to cover skew from lane to lane.

Each lane runs a small state machine with three states: `GS_IDLE`, `GS_PRE` and `GS_BURST`. The transitions are:
- **open**: `GS_IDLE` goes to `GS_PRE` when a lane start arrives.
- **arm**: `GS_PRE` goes to `GS_BURST` after its two cycles.
- **chain**: `GS_BURST` goes back to `GS_BURST` with the count reloaded when a back-to-back read is pending.
- **reopen**: `GS_BURST` goes to `GS_PRE` when the next read's preamble starts right after this burst.
- **close**: `GS_BURST` goes to `GS_IDLE` when no further read follows.
- **kill**: any state goes to `GS_IDLE` on a write command or on reset.

Top module: `rd_strobe_gate`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, every gate, gated strobe, edge and error output is 0, and `dqs_oe_o` is 0.
- R2: A read command sampled in cycle c opens the gate of lane l from cycle c+2·Le+Ol for 2+B cycles. Le is `rd_lat_i` with 0 treated as 1 and values above MAX_LAT treated as MAX_LAT. Ol is that lane's offset. B comes from `burst_sel_i`: 0 gives 2, 1 gives 4, and 2 or 3 give 8.
- R3: Lane l's offset is `lane_ofs_i[2l+1:2l]`, and each lane times its own window with its own offset.
- R4: `dqs_g_o[l]` equals `dqs_i[l]` while the gate of lane l is open and is 0 while it is closed, whatever the floating strobe does.
- R5: `rise_o[l]` is 1 in a cycle where the gate is open, the strobe is 1, and the gated strobe of the previous cycle was 0. `fall_o[l]` is 1 where the gate is open, the strobe is 0, and the previous gated strobe was 1.
- R6: A second read issued exactly B cycles after the first keeps the gate open without a break until its own burst ends, and no preamble check is made for it.
- R7: A read issued B+2 cycles after the previous one starts its preamble in the cycle right after the previous burst. The gate stays open, and the new preamble is checked.
- R8: If the strobe is 1 in either preamble cycle of a checked window, `err_o[l]` is 1 in the following cycle.
- R9: If no rising edge appears in either of the first two burst cycles after a checked preamble, `err_o[l]` is 1 in the cycle after the second burst cycle.
- R10: A write command closes every gate in the same cycle and clears every scheduled or running read window. A read command given in the same cycle as a write is ignored.
- R11: `dqs_oe_o` becomes 1 in the cycle after a write command and 0 in the cycle after a read command given without a write, and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-memory-cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_cmd_i | input | 1 | Read command issued this cycle |
| wr_cmd_i | input | 1 | Write command issued this cycle |
| rd_lat_i | input | LATW | Read latency in memory cycles |
| burst_sel_i | input | 2 | Burst length select |
| lane_ofs_i | input | 2·LANES | Per-lane start offset in half cycles |
| dqs_i | input | LANES | Sampled strobe per lane |
| gate_o | output | LANES | Gate open per lane |
| dqs_g_o | output | LANES | Gated strobe level |
| rise_o | output | LANES | Rising edge inside the gate |
| fall_o | output | LANES | Falling edge inside the gate |
| err_o | output | LANES | Preamble or first-edge fault pulse |
| dqs_oe_o | output | 1 | Strobe pad drive enable |

## Verification
A write command can land in the same cycle as the cycle in which a lane's preamble begins, or in the same cycle as a read command. In that cycle the kill and open paths compete for the lane.

The bench provokes both cases:
- It issues a write at a fixed distance after a read, so that the write hits a window that is either still pending or already open.
- It issues a read and a write together.

The behavioural model is judged cycle by cycle. The gate must drop in the write cycle and must never reopen for the discarded read. No error pulse may leak out of the cycle that was killed.

Chaining and reopening also fall on the last burst cycle of the window before. The bench judges them by checking that the gate is continuous and that the preamble is checked only when the model expects a fresh window.

// File: rtl/rsg_pkg.sv
package rsg_pkg;

    typedef enum logic [1:0] {
        GS_IDLE  = 2'd0,
        GS_PRE   = 2'd1,
        GS_BURST = 2'd2
    } gate_st_t;

    // Burst length in beats (= clk cycles of burst) from the select code
    function automatic logic [3:0] burst_beats(input logic [1:0] sel);
        logic [3:0] b;
        case (sel)
            2'd0:    b = 4'd2;
            2'd1:    b = 4'd4;
            default: b = 4'd8;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/rsg_tap_line.sv
module rsg_tap_line #(
    parameter int DEPTH = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             kill,
    input  logic             push,
    output logic [DEPTH-1:0] line_o
);

    logic [DEPTH-1:0] line;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            line <= '0;
        else if (kill)
            line <= '0;
        else
            line <= {line[DEPTH-2:0], push};
    end

    assign line_o = line;

endmodule

// File: rtl/rsg_lane.sv
module rsg_lane
    import rsg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       kill,
    input  logic       start,
    input  logic [3:0] beats,
    input  logic       dqs_i,
    output logic       gate_o,
    output logic       dqs_g_o,
    output logic       rise_o,
    output logic       fall_o,
    output logic       err_o
);

    gate_st_t   st, st_n;
    logic [3:0] cnt, cnt_n;
    logic       chain, chain_n;
    logic       fresh, fresh_n;
    logic       seen, seen_n;
    logic       viol;
    logic       prev_g;
    logic       err_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= GS_IDLE;
            cnt    <= '0;
            chain  <= 1'b0;
            fresh  <= 1'b0;
            seen   <= 1'b0;
            prev_g <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            st     <= st_n;
            cnt    <= cnt_n;
            chain  <= chain_n;
            fresh  <= fresh_n;
            seen   <= seen_n;
            prev_g <= dqs_g_o;
            err_q  <= viol & ~kill;
        end
    end

    // outputs
    always_comb begin
        gate_o  = (st != GS_IDLE) && !kill;
        dqs_g_o = gate_o & dqs_i;
        rise_o  = gate_o & dqs_i & ~prev_g;
        fall_o  = gate_o & ~dqs_i & prev_g;
        err_o   = err_q;
    end

    // next state
    always_comb begin
        st_n    = st;
        cnt_n   = cnt;
        chain_n = chain;
        fresh_n = fresh;
        seen_n  = seen;
        viol    = 1'b0;
        if (kill) begin
            st_n    = GS_IDLE;
            cnt_n   = '0;
            chain_n = 1'b0;
            fresh_n = 1'b0;
            seen_n  = 1'b0;
        end else begin
            unique case (st)
                GS_IDLE: begin
                    if (start) begin
                        st_n  = GS_PRE;
                        cnt_n = 4'd2;
                    end
                end
                GS_PRE: begin
                    viol = dqs_i;
                    if (start) chain_n = 1'b1;
                    if (cnt == 4'd1) begin
                        st_n    = GS_BURST;
                        cnt_n   = beats;
                        fresh_n = 1'b1;
                        seen_n  = 1'b0;
                    end else begin
                        cnt_n = cnt - 4'd1;
                    end
                end
                GS_BURST: begin
                    if (fresh && cnt == beats) seen_n = rise_o;
                    if (fresh && cnt == beats - 4'd1) begin
                        viol    = !(seen | rise_o);
                        fresh_n = 1'b0;
                    end
                    if (cnt == 4'd1) begin
                        if (chain) begin
                            cnt_n   = beats;
                            chain_n = 1'b0;
                            fresh_n = 1'b0;
                        end else if (start) begin
                            st_n  = GS_PRE;
                            cnt_n = 4'd2;
                        end else begin
                            st_n = GS_IDLE;
                        end
                    end else begin
                        cnt_n = cnt - 4'd1;
                        if (start) chain_n = 1'b1;
                    end
                end
                default: st_n = GS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rd_strobe_gate.sv
module rd_strobe_gate
    import rsg_pkg::*;
#(
    parameter int LANES   = 4,
    parameter int MAX_LAT = 8,
    parameter int LATW    = $clog2(MAX_LAT + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_cmd_i,
    input  logic               wr_cmd_i,
    input  logic [LATW-1:0]    rd_lat_i,
    input  logic [1:0]         burst_sel_i,
    input  logic [2*LANES-1:0] lane_ofs_i,
    input  logic [LANES-1:0]   dqs_i,
    output logic [LANES-1:0]   gate_o,
    output logic [LANES-1:0]   dqs_g_o,
    output logic [LANES-1:0]   rise_o,
    output logic [LANES-1:0]   fall_o,
    output logic [LANES-1:0]   err_o,
    output logic               dqs_oe_o
);

    localparam int DEPTH = 2 * MAX_LAT + 2;
    localparam int IDXW  = $clog2(DEPTH);

    logic [LATW-1:0]  lat_eff;
    logic [IDXW-1:0]  base_idx;
    logic [DEPTH-1:0] line;
    logic [3:0]       beats;
    logic             oe_q;

    always_comb begin
        if (rd_lat_i == '0)
            lat_eff = LATW'(1);
        else if (rd_lat_i > LATW'(MAX_LAT))
            lat_eff = LATW'(MAX_LAT);
        else
            lat_eff = rd_lat_i;
    end

    assign base_idx = IDXW'({lat_eff, 1'b0}) - IDXW'(2);
    assign beats    = burst_beats(burst_sel_i);

    rsg_tap_line #(.DEPTH(DEPTH)) u_line (
        .clk    (clk),
        .rst_n  (rst_n),
        .kill   (wr_cmd_i),
        .push   (rd_cmd_i & ~wr_cmd_i),
        .line_o (line)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [IDXW-1:0] tap_idx;
        assign tap_idx = base_idx + IDXW'(lane_ofs_i[2*l +: 2]);

        rsg_lane u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .kill    (wr_cmd_i),
            .start   (line[tap_idx]),
            .beats   (beats),
            .dqs_i   (dqs_i[l]),
            .gate_o  (gate_o[l]),
            .dqs_g_o (dqs_g_o[l]),
            .rise_o  (rise_o[l]),
            .fall_o  (fall_o[l]),
            .err_o   (err_o[l])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            oe_q <= 1'b0;
        else if (wr_cmd_i)
            oe_q <= 1'b1;
        else if (rd_cmd_i)
            oe_q <= 1'b0;
    end

    assign dqs_oe_o = oe_q;

endmodule

// File: rtl/rsg_checker.sv
module rsg_checker #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_cmd_i,
    input logic             wr_cmd_i,
    input logic [LANES-1:0] gate_o,
    input logic [LANES-1:0] rise_o,
    input logic [LANES-1:0] err_o,
    input logic             dqs_oe_o
);

    for (genvar l = 0; l < LANES; l++) begin : g_chk
        // R5
        rise_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rise_o[l] |=> !rise_o[l]);
        // R2
        pre_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(gate_o[l]) |=> (gate_o[l] || wr_cmd_i));
        // R8
        err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            err_o[l] |-> $past(gate_o[l]));
    end

    // R10
    wr_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cmd_i |=> (gate_o == '0 && err_o == '0));
    // R11
    oe_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cmd_i |=> dqs_oe_o);
    // R11
    oe_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cmd_i && !wr_cmd_i) |=> !dqs_oe_o);

endmodule

bind rd_strobe_gate rsg_checker #(.LANES(LANES)) u_rsg_chk (.*);

// File: tb/rd_strobe_gate_test.sv
`timescale 1ns/1ps
module rd_strobe_gate_test;

    localparam int LANES   = 4;
    localparam int MAX_LAT = 8;
    localparam int LATW    = $clog2(MAX_LAT + 1);

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               rd_cmd = 1'b0, wr_cmd = 1'b0;
    logic [LATW-1:0]    rd_lat = LATW'(3);
    logic [1:0]         bsel = 2'd1;
    logic [2*LANES-1:0] ofs_v = {2'd3, 2'd2, 2'd1, 2'd0};
    logic [LANES-1:0]   dqs = '0;
    logic [LANES-1:0]   gate, dqs_g, rise, fall, err;
    logic               oe;

    rd_strobe_gate #(.LANES(LANES), .MAX_LAT(MAX_LAT)) uut (
        .clk(clk), .rst_n(rst_n), .rd_cmd_i(rd_cmd), .wr_cmd_i(wr_cmd),
        .rd_lat_i(rd_lat), .burst_sel_i(bsel), .lane_ofs_i(ofs_v),
        .dqs_i(dqs), .gate_o(gate), .dqs_g_o(dqs_g), .rise_o(rise),
        .fall_o(fall), .err_o(err), .dqs_oe_o(oe)
    );

    always #2.5 clk = ~clk;

    int    total = 0, failed = 0, cyc = 0;
    string cur_req = "R1";

    int q[LANES][$];
    int win_beg[LANES], win_end[LANES], pre_at[LANES], bbase[LANES];
    bit f_pre[LANES], f_miss[LANES];
    bit prev_m[LANES], rise_last[LANES], err_pend[LANES];
    bit oe_m = 1'b0;

    task automatic check(string tag, string what, int lane, logic got, logic exp);
        total++;
        if (got !== exp) begin
            failed++;
            $display("FAIL %s %s lane %0d cycle %0d got %b exp %b", tag, what, lane, cyc, got, exp);
        end
    endtask

    function automatic int eff_lat();
        if (rd_lat == 0) return 1;
        if (rd_lat > MAX_LAT) return MAX_LAT;
        return int'(rd_lat);
    endfunction

    function automatic int blen();
        return (bsel == 2'd0) ? 2 : (bsel == 2'd1) ? 4 : 8;
    endfunction

    task automatic step(input bit rd, input bit wr);
        logic [LANES-1:0] dv;
        @(negedge clk);
        rd_cmd = rd;
        wr_cmd = wr;
        if (rst_n && rd && !wr)
            for (int l = 0; l < LANES; l++)
                q[l].push_back(cyc + 2 * eff_lat() + int'(ofs_v[2*l +: 2]));
        for (int l = 0; l < LANES; l++) begin
            if (q[l].size() > 0 && q[l][0] == cyc) begin
                void'(q[l].pop_front());
                if (cyc > win_end[l]) begin
                    win_beg[l] = cyc;
                    pre_at[l]  = cyc;
                    bbase[l]   = cyc + 2;
                    win_end[l] = cyc + 1 + blen();
                end else if (cyc == win_end[l] - 1) begin
                    win_end[l] += blen();
                end
            end
            if (cyc >= win_beg[l] && cyc <= win_end[l]) begin
                if (cyc < pre_at[l] + 2 && cyc >= pre_at[l])
                    dv[l] = f_pre[l] && (cyc == pre_at[l] + 1);
                else if (f_miss[l] && cyc < pre_at[l] + 4)
                    dv[l] = 1'b0;
                else
                    dv[l] = ((cyc - bbase[l]) % 2) == 0;
            end else begin
                dv[l] = 1'($urandom % 2);
            end
        end
        dqs = dv;
        #1;
        for (int l = 0; l < LANES; l++) begin
            bit g, eg, er, ef, vio;
            g  = rst_n && !wr && cyc >= win_beg[l] && cyc <= win_end[l];
            eg = g && dv[l];
            er = eg && !prev_m[l];
            ef = g && !dv[l] && prev_m[l];
            check(cur_req, "gate", l, gate[l], g);
            check("R4", "dqs_g", l, dqs_g[l], eg);
            check("R5", "rise", l, rise[l], er);
            check("R5", "fall", l, fall[l], ef);
            check("R8 R9", "err", l, err[l], err_pend[l]);
            vio = g && (((cyc == pre_at[l] || cyc == pre_at[l] + 1) && dv[l]) ||
                        (cyc == pre_at[l] + 3 && !(rise_last[l] || er)));
            err_pend[l]  = vio;
            prev_m[l]    = eg;
            rise_last[l] = er;
            if (cyc == pre_at[l] + 3) begin
                f_pre[l]  = 1'b0;
                f_miss[l] = 1'b0;
            end
            if (wr || !rst_n) begin
                q[l].delete();
                win_beg[l] = -100;
                win_end[l] = -100;
                pre_at[l]  = -100;
            end
        end
        check("R11", "oe", 0, oe, oe_m);
        if (!rst_n) oe_m = 1'b0;
        else if (wr) oe_m = 1'b1;
        else if (rd) oe_m = 1'b0;
        cyc++;
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) step(1'b0, 1'b0);
    endtask

    initial begin
        #250000;
        failed++;
        total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        for (int l = 0; l < LANES; l++) begin
            win_beg[l] = -100; win_end[l] = -100; pre_at[l] = -100; bbase[l] = 0;
            f_pre[l] = 0; f_miss[l] = 0; prev_m[l] = 0; rise_last[l] = 0; err_pend[l] = 0;
        end
        // R1 reset state
        cur_req = "R1";
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R2 R3 single reads, several latencies and lengths
        cur_req = "R2 R3";
        step(1, 0); idle(20);
        bsel = 2'd0; rd_lat = LATW'(2);
        step(1, 0); idle(16);
        bsel = 2'd2; rd_lat = LATW'(5);
        step(1, 0); idle(25);
        bsel = 2'd3; rd_lat = LATW'(0);
        step(1, 0); idle(20);
        bsel = 2'd1; rd_lat = LATW'(12);
        ofs_v = {2'd0, 2'd3, 2'd1, 2'd2};
        step(1, 0); idle(30);
        // R6 back-to-back, no gap
        cur_req = "R6";
        rd_lat = LATW'(3);
        step(1, 0); idle(3); step(1, 0); idle(3); step(1, 0); idle(25);
        bsel = 2'd0;
        step(1, 0); idle(1); step(1, 0); idle(20);
        // R7 adjacent preamble
        cur_req = "R7";
        bsel = 2'd1;
        step(1, 0); idle(5); step(1, 0); idle(25);
        // R8 R9 faults
        cur_req = "R8";
        f_pre[1] = 1'b1;
        step(1, 0); idle(25);
        cur_req = "R9";
        f_miss[2] = 1'b1; f_miss[0] = 1'b1;
        step(1, 0); idle(25);
        f_pre[3] = 1'b1;
        step(1, 0); idle(5); step(1, 0); idle(25);
        // R10 writes
        cur_req = "R10";
        step(1, 0); idle(8); step(0, 1); idle(20);
        step(1, 0); idle(2); step(0, 1); idle(20);
        step(1, 1); idle(20);
        step(1, 0); idle(5); step(0, 1); idle(20);
        bsel = 2'd2;
        step(1, 0); idle(7); step(1, 0); idle(10); step(0, 1); idle(25);
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

endmodule